// File: doc/BRIEF.md
# Dual-Channel Microstep Current-Code Register Front End

This block is the digital front end of a two-channel current-setting device for a stepper-motor driver. A host writes it over an 8-bit parallel write bus made of a data byte, an active-low select, an active-low write strobe and two address lines. Each channel holds a 7-bit current code with a direction sign, and a 3-bit threshold that decides when a falling current step calls for fast decay.

Every time a channel's code is written, the block compares the incoming code with the code that channel held until then, and compares the top three bits of the incoming code with the channel's threshold. If the new code is below both, the channel's registered active-low decay flag goes low (fast decay). Otherwise it goes high (slow decay). The flag then holds until the next code write to that channel. The bus is sampled in the system clock domain. A write takes effect on the clock edge at which the strobe is seen returning high while the select is low.

Top module: `ustep_dac_front`

## Requirements
- R1: After the asynchronous active-low reset, every code and sign output is 0, every decay flag is 1 and every threshold is 0. With threshold 0, a falling code write leaves the flag at 1.
- R2: A write happens only when the strobe rises while the select is low. A strobe cycle with the select high changes no output.
- R3: Address bit 1 chooses the register kind, with 0 for code and 1 for threshold. Address bit 0 chooses the channel, with 0 for channel 1 and 1 for channel 2.
- R4: A code write loads data bits 6..0 as the channel's code and data bit 7 as its sign. These become visible on the clock edge that detects the strobe rise.
- R5: A threshold write loads data bits 2..0 and ignores bits 7..3. It leaves the decay flag, code and sign unchanged, and the new threshold applies from the next code write.
- R6: On a code write the flag becomes 0 exactly when the new code is strictly less than the previously held code and new code bits 6..4 are strictly less than the threshold. Otherwise it becomes 1.
- R7: Between code writes to a channel, its decay flag holds its value.
- R8: A write to one channel changes no output of the other channel.
- R9: One strobe pulse causes exactly one write, however long the strobe stays high or low. Rewriting the same code sets the flag to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 8 | Write data byte |
| bus_addr | input | 2 | Register select: bit 1 kind, bit 0 channel |
| bus_cs_n | input | 1 | Active-low select |
| bus_wr_n | input | 1 | Active-low write strobe, captured on its rising edge |
| code_o | output | 14 | Channel codes, channel 1 in bits 6..0 and channel 2 in bits 13..7 |
| sign_o | output | 2 | Direction sign per channel, bit 0 for channel 1 |
| fast_n_o | output | 2 | Active-low fast-decay flag per channel, bit 0 for channel 1 |

## Verification
The hardest case to reach is a low flag, which needs three things at once. The previous code must be above the new one, the threshold must be above the new code's top bits, and that threshold must have been written before the code. The bench therefore writes each threshold 0..7 to a channel, then steps through many ordered pairs of codes (old then new), including equal, rising and falling pairs on both sides of the threshold. After every write it compares all outputs of both channels against an arithmetic model. A long-held strobe shows whether the same code is written again, because a second evaluation of an equal code would turn the flag high.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned CODE_W  = 7;
    localparam int unsigned LVL_W   = 3;
    localparam int unsigned NUM_CH  = 2;
endpackage

// File: rtl/ustep_bus_if.sv
module ustep_bus_if #(
    parameter int unsigned NUM_CH = ustep_pkg::NUM_CH,
    parameter int unsigned ADDR_W = $clog2(NUM_CH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              wr_n,
    output logic [NUM_CH-1:0] code_ld,
    output logic [NUM_CH-1:0] lvl_ld
);
    localparam int unsigned CH_W = ADDR_W - 1;

    typedef struct packed {
        logic wr_n;
    } bus_st_t;

    bus_st_t st_d, st_q;
    logic    wr_rise;
    logic [CH_W-1:0] ch_sel;

    always_comb begin
        st_d      = st_q;
        st_d.wr_n = wr_n;
        wr_rise   = wr_n && !st_q.wr_n && !cs_n;
        ch_sel    = addr[CH_W-1:0];
        code_ld   = '0;
        lvl_ld    = '0;
        for (int i = 0; i < int'(NUM_CH); i++) begin
            if (wr_rise && (ch_sel == CH_W'(i))) begin
                code_ld[i] = !addr[ADDR_W-1];
                lvl_ld[i]  =  addr[ADDR_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{wr_n: 1'b1};
        else        st_q <= st_d;
    end

    // R9: one strobe edge produces at most one load of any kind
    a_r9_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({code_ld, lvl_ld}) <= 1);
    // R9: no load in two consecutive cycles from a single edge
    a_r9_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (|{code_ld, lvl_ld}) |=> !(|{code_ld, lvl_ld}));
    // R2: a deselected bus never loads
    a_r2_cs_gates: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !(|{code_ld, lvl_ld}));
endmodule

// File: rtl/ustep_chan.sv
module ustep_chan #(
    parameter int unsigned DATA_W = ustep_pkg::DATA_W,
    parameter int unsigned CODE_W = ustep_pkg::CODE_W,
    parameter int unsigned LVL_W  = ustep_pkg::LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_ld,
    input  logic              lvl_ld,
    input  logic [DATA_W-1:0] wdata,
    output logic [CODE_W-1:0] code,
    output logic              sign,
    output logic              fast_n
);
    localparam int unsigned SIGN_BIT = CODE_W;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              sign;
        logic [LVL_W-1:0]  lvl;
        logic              fast_n;
    } ch_st_t;

    ch_st_t            st_d, st_q;
    logic [CODE_W-1:0] new_code;
    logic              step_down;
    logic              under_lvl;

    always_comb begin
        st_d      = st_q;
        new_code  = wdata[CODE_W-1:0];
        step_down = new_code < st_q.code;
        under_lvl = new_code[CODE_W-1 -: LVL_W] < st_q.lvl;
        if (code_ld) begin
            st_d.code   = new_code;
            st_d.sign   = wdata[SIGN_BIT];
            st_d.fast_n = !(step_down && under_lvl);
        end
        if (lvl_ld) begin
            st_d.lvl = wdata[LVL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{code: '0, sign: 1'b0, lvl: '0, fast_n: 1'b1};
        else        st_q <= st_d;
    end

    assign code   = st_q.code;
    assign sign   = st_q.sign;
    assign fast_n = st_q.fast_n;

    // R7: flag changes only following a code load
    a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !code_ld |=> $stable(fast_n));
    // R5: a threshold load leaves code, sign and flag alone
    a_r5_lvl_keeps_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_ld && !code_ld) |=> ($stable(fast_n) && $stable(code) && $stable(sign)));
    // R4: code and sign follow the written byte one edge later
    a_r4_code_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        code_ld |=> (code == $past(wdata[CODE_W-1:0]) && sign == $past(wdata[SIGN_BIT])));
    // R6: a rising or equal code always yields slow decay
    a_r6_no_fast_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (code_ld && wdata[CODE_W-1:0] >= code) |=> fast_n);
endmodule

// File: rtl/ustep_dac_front.sv
module ustep_dac_front #(
    parameter int unsigned DATA_W = ustep_pkg::DATA_W,
    parameter int unsigned CODE_W = ustep_pkg::CODE_W,
    parameter int unsigned LVL_W  = ustep_pkg::LVL_W,
    parameter int unsigned NUM_CH = ustep_pkg::NUM_CH,
    parameter int unsigned ADDR_W = $clog2(NUM_CH) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        bus_data,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_cs_n,
    input  logic                     bus_wr_n,
    output logic [NUM_CH*CODE_W-1:0] code_o,
    output logic [NUM_CH-1:0]        sign_o,
    output logic [NUM_CH-1:0]        fast_n_o
);
    logic [NUM_CH-1:0] code_ld;
    logic [NUM_CH-1:0] lvl_ld;

    ustep_bus_if #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .cs_n    (bus_cs_n),
        .wr_n    (bus_wr_n),
        .code_ld (code_ld),
        .lvl_ld  (lvl_ld)
    );

    for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
        ustep_chan #(
            .DATA_W (DATA_W),
            .CODE_W (CODE_W),
            .LVL_W  (LVL_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .code_ld (code_ld[g]),
            .lvl_ld  (lvl_ld[g]),
            .wdata   (bus_data),
            .code    (code_o[g*CODE_W +: CODE_W]),
            .sign    (sign_o[g]),
            .fast_n  (fast_n_o[g])
        );
    end

    // R8: a load on one channel leaves the other channel's code stable
    a_r8_other_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (code_ld == 2'b01) |=> $stable(code_o[2*CODE_W-1:CODE_W]));
endmodule

// File: tb/ustep_dac_front_test.sv
`timescale 1ns/1ps
module ustep_dac_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_data = '0;
    logic [1:0]  bus_addr = '0;
    logic        bus_cs_n = 1'b1;
    logic        bus_wr_n = 1'b1;
    logic [13:0] code_o;
    logic [1:0]  sign_o;
    logic [1:0]  fast_n_o;

    int n_run = 0;
    int n_fail = 0;
    logic [6:0] m_code [2];
    logic       m_sign [2];
    logic [2:0] m_lvl  [2];
    logic       m_fast [2];

    always #10 clk = ~clk;

    ustep_dac_front uut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
        .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .code_o(code_o), .sign_o(sign_o), .fast_n_o(fast_n_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < 2; c++) begin
            chk({tag, " code"}, int'(code_o[c*7 +: 7]), int'(m_code[c]));
            chk({tag, " sign"}, int'(sign_o[c]), int'(m_sign[c]));
            chk({tag, " flag"}, int'(fast_n_o[c]), int'(m_fast[c]));
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic cs_n_v,
                             input int hold);
        @(negedge clk);
        bus_addr = a; bus_data = d; bus_cs_n = cs_n_v; bus_wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        bus_wr_n = 1'b1;
        repeat (hold + 1) @(negedge clk);
        bus_cs_n = 1'b1;
    endtask

    // R3/R4/R6: code write through address {0, ch}
    task automatic write_code(input int ch, input logic [6:0] v, input logic s, input int hold);
        m_fast[ch] = !((v < m_code[ch]) && (v[6:4] < m_lvl[ch]));
        m_code[ch] = v;
        m_sign[ch] = s;
        bus_write({1'b0, ch[0]}, {s, v}, 1'b0, hold);
        check_all("R6");
    endtask

    // R3/R5: threshold write through address {1, ch}, upper bits junk
    task automatic write_lvl(input int ch, input logic [2:0] l);
        m_lvl[ch] = l;
        bus_write({1'b1, ch[0]}, {5'b10110, l}, 1'b0, 1);
        check_all("R5");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_code[c] = '0; m_sign[c] = 1'b0; m_lvl[c] = '0; m_fast[c] = 1'b1;
        end
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R1 after release");

        // R1: threshold 0 after reset, falling step stays slow
        write_code(0, 7'd127, 1'b1, 1);
        write_code(0, 7'd0, 1'b0, 1);
        chk("R1 lvl0 flag", int'(fast_n_o[0]), 1);

        // R2: deselected strobe is ignored
        bus_write(2'b00, 8'h55, 1'b1, 1);
        check_all("R2 cs high");
        bus_write(2'b10, 8'h07, 1'b1, 1);
        write_code(0, 7'd10, 1'b0, 1);
        write_code(0, 7'd5, 1'b0, 1);
        chk("R2 lvl unchanged", int'(fast_n_o[0]), 1);

        // R9: long strobe, falling step to fast, held high long
        write_lvl(1, 3'd7);
        write_code(1, 7'd100, 1'b0, 1);
        write_code(1, 7'd20, 1'b1, 6);
        chk("R9 single eval", int'(fast_n_o[1]), 0);
        // R5: threshold write keeps flag low
        write_lvl(1, 3'd0);
        chk("R5 flag kept", int'(fast_n_o[1]), 0);
        // R9: same code again gives slow
        write_code(1, 7'd20, 1'b1, 1);
        chk("R9 equal rewrite", int'(fast_n_o[1]), 1);

        // R6/R7/R8: sweep thresholds and old/new pairs on each channel
        for (int c = 0; c < 2; c++) begin
            for (int l = 0; l < 8; l++) begin
                write_lvl(c, 3'(l));
                for (int o = 0; o < 128; o += 11) begin
                    for (int n = 0; n < 128; n += 3) begin
                        write_code(c, 7'(o), 1'(o ^ n), 1);
                        write_code(c, 7'(n), 1'(n), 1);
                    end
                end
                // boundaries: top code and threshold edges
                write_code(c, 7'd127, 1'b1, 1);
                write_code(c, 7'(l * 16), 1'b0, 1);
                write_code(c, 7'(l * 16 + 1), 1'b0, 1);
                write_code(c, 7'(l * 16), 1'b1, 1);
                // R7: idle cycles keep everything
                repeat (5) @(negedge clk);
                check_all("R7 idle");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule